// File: doc/BRIEF.md
# Vector Logic and Arithmetic Unit

This block runs one logic or arithmetic instruction at a time over a run of consecutive registers in a 128-entry, 32-bit register file that sits outside the block. A 32-bit instruction word arrives over a valid/ready handshake. The block decodes it and then steps through the elements, one per clock. For each element it drives two combinational read indices, gets the two read values back in the same cycle, and issues at most one register write.

The second operand can take three forms: a vector that steps with the destination, a scalar register that stays fixed, or a 7-bit signed immediate. Two operations behave differently from the rest. The reduction form adds every element of the A run to a scalar and writes a single result. The absolute-value form adds B to a fixed A register, or subtracts B from it when B is negative; with A set to register 0 this gives |B|.

Top module: `vec_alu`

## Requirements
- R1: After reset, `instr_ready` is high, and `busy` and `wr_en` are low. An instruction is taken on a clock edge where `instr_valid` and `instr_ready` are both high. For a recognised group, `busy` is high from the next cycle through the cycle of its last element. `instr_ready` equals the inverse of `busy`.
- R2: The element count is bits 27:24 plus one, giving 1 to 16 elements. Element i is handled i+1 cycles after acceptance. The destination of element i is bits 13:7 plus i.
- R3: Bits 31:28 select the group: 0xB is the logic group and 0xA is the arithmetic group. A word with any other value is accepted and dropped. It causes no write and no busy cycle.
- R4: In the logic group, bits 23:21 select the operation: 0 and 3 and 6 are AND, XOR and OR with a vector B; 1 and 4 and 7 are AND, XOR and OR with a scalar B; 2 and 5 are AND and XOR with an immediate.
- R5: In the arithmetic group, bits 23:21 select the operation: 0, 1 and 2 are A+B with vector, scalar and immediate B; 4, 5 and 6 are A−B in the same three forms. All sums and differences wrap modulo 2^32.
- R6: The A index is bits 20:14 and the B field is bits 6:0. In vector forms both A and B step by one per element. In scalar forms B keeps the index from bits 6:0. In immediate forms, bits 6:0 are sign-extended to 32 bits and used as the same value for every element.
- R7: Arithmetic sub-op 3 takes the scalar B and adds it to all A elements of the run. It writes exactly one result, to the destination index, in the cycle of the last element.
- R8: Arithmetic sub-op 7 writes A−B when bit 31 of B is set and A+B otherwise. A stays at its starting index, while B and the destination step.
- R9: Reading index 0 gives zero, whatever data the register file returns for it.
- R10: A write aimed at index 0 is dropped: `wr_en` stays low in that element's cycle, and the later elements still go ahead.
- R11: Register indices for A, B and the destination wrap modulo 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_valid | input | 1 | Instruction word is offered |
| instr_word | input | 32 | Instruction word |
| instr_ready | output | 1 | Block can take an instruction |
| busy | output | 1 | An instruction is being stepped through |
| rda_idx | output | 7 | Register index for operand A |
| rda_data | input | 32 | Register file data at `rda_idx`, same cycle |
| rdb_idx | output | 7 | Register index for operand B |
| rdb_data | input | 32 | Register file data at `rdb_idx`, same cycle |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 7 | Register index to write |
| wr_data | output | 32 | Data to write |

## Verification
The hardest cases to reach are runs whose index ranges wrap past 127 and overlap one another. In these runs a write to register 0 must be dropped partway through the run, and a later element must read a register that an earlier element of the same instruction has just written. Random stimulus draws indices and counts across the whole range, so wrapping and overlap happen often. Directed words aimed at indices 125 to 127 force the dropped write mid-run. Register 0 in the bench register file holds a nonzero pattern, so any read of index 0 that is not forced to zero, and any write that reaches it, shows up in the register-file comparison.

// File: rtl/vec_alu_pkg.sv
// Package: shared widths, operation codes and the decoded-instruction record.
// Assumes the fixed instruction layout: group 31:28, count 27:24,
// sub-op 23:21, A 20:14, destination 13:7, B 6:0.
package vec_alu_pkg;
    parameter int DATA_W  = 32;
    parameter int IDX_W   = 7;
    parameter int CNT_W   = 4;
    parameter int IMM_W   = 7;
    parameter int SUB_W   = 3;
    parameter int GRP_W   = 4;
    parameter logic [GRP_W-1:0] GRP_LOGIC = 4'hB;
    parameter logic [GRP_W-1:0] GRP_ARITH = 4'hA;

    localparam int B_LSB   = 0;
    localparam int D_LSB   = B_LSB + IDX_W;
    localparam int A_LSB   = D_LSB + IDX_W;
    localparam int SUB_LSB = A_LSB + IDX_W;
    localparam int CNT_LSB = SUB_LSB + SUB_W;
    localparam int GRP_LSB = CNT_LSB + CNT_W;
    localparam int WORD_W  = GRP_LSB + GRP_W;

    typedef enum logic [2:0] {
        OP_AND, OP_XOR, OP_OR, OP_ADD, OP_SUB, OP_ABS
    } op_e;

    typedef enum logic [2:0] {
        MD_VEC, MD_SCL, MD_IMM, MD_SUM, MD_ABS
    } mode_e;

    typedef struct packed {
        logic              valid;
        op_e               op;
        mode_e             mode;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  a;
        logic [IDX_W-1:0]  d;
        logic [IDX_W-1:0]  b;
        logic [DATA_W-1:0] imm;
    } instr_t;
endpackage

// File: rtl/vec_alu_decode.sv
// Decoder: splits an instruction word into fields and maps group plus
// sub-op onto an operation and an operand form.
// Assumes: purely combinational; words of an unknown group yield valid=0.
module vec_alu_decode
    import vec_alu_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output instr_t            dec
);
    logic [GRP_W-1:0] grp;
    logic [SUB_W-1:0] sub;
    logic [IMM_W-1:0] imm_raw;

    assign grp     = word[GRP_LSB +: GRP_W];
    assign sub     = word[SUB_LSB +: SUB_W];
    assign imm_raw = word[B_LSB +: IMM_W];

    // Field extraction and operation/form lookup
    always_comb begin
        dec       = '0;
        dec.cnt   = word[CNT_LSB +: CNT_W];
        dec.a     = word[A_LSB +: IDX_W];
        dec.d     = word[D_LSB +: IDX_W];
        dec.b     = word[B_LSB +: IDX_W];
        dec.imm   = {{(DATA_W-IMM_W){imm_raw[IMM_W-1]}}, imm_raw};
        dec.valid = (grp == GRP_LOGIC) || (grp == GRP_ARITH);
        dec.op    = OP_AND;
        dec.mode  = MD_VEC;
        if (grp == GRP_LOGIC) begin
            unique case (sub)
                3'd0: begin dec.op = OP_AND; dec.mode = MD_VEC; end
                3'd1: begin dec.op = OP_AND; dec.mode = MD_SCL; end
                3'd2: begin dec.op = OP_AND; dec.mode = MD_IMM; end
                3'd3: begin dec.op = OP_XOR; dec.mode = MD_VEC; end
                3'd4: begin dec.op = OP_XOR; dec.mode = MD_SCL; end
                3'd5: begin dec.op = OP_XOR; dec.mode = MD_IMM; end
                3'd6: begin dec.op = OP_OR;  dec.mode = MD_VEC; end
                default: begin dec.op = OP_OR; dec.mode = MD_SCL; end
            endcase
        end else begin
            unique case (sub)
                3'd0: begin dec.op = OP_ADD; dec.mode = MD_VEC; end
                3'd1: begin dec.op = OP_ADD; dec.mode = MD_SCL; end
                3'd2: begin dec.op = OP_ADD; dec.mode = MD_IMM; end
                3'd3: begin dec.op = OP_ADD; dec.mode = MD_SUM; end
                3'd4: begin dec.op = OP_SUB; dec.mode = MD_VEC; end
                3'd5: begin dec.op = OP_SUB; dec.mode = MD_SCL; end
                3'd6: begin dec.op = OP_SUB; dec.mode = MD_IMM; end
                default: begin dec.op = OP_ABS; dec.mode = MD_ABS; end
            endcase
        end
    end
endmodule

// File: rtl/vec_alu_lane.sv
// Lane: computes one element result from two 32-bit operands.
// Assumes operands are already zero-forced for index 0 and immediates
// already sign-extended; arithmetic wraps at DATA_W bits.
module vec_alu_lane
    import vec_alu_pkg::*;
(
    input  op_e               op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] res
);
    // Element operation select
    always_comb begin
        unique case (op)
            OP_AND:  res = opa & opb;
            OP_XOR:  res = opa ^ opb;
            OP_OR:   res = opa | opb;
            OP_ADD:  res = opa + opb;
            OP_SUB:  res = opa - opb;
            default: res = opb[DATA_W-1] ? (opa - opb) : (opa + opb);
        endcase
    end
endmodule

// File: rtl/vec_alu_seq.sv
// Sequencer: holds the accepted instruction, walks the element indices,
// forms operands from the register read data, and drives the write port.
// Assumes a register file with combinational reads and writes taking
// effect at the clock edge, so element i+1 sees the write of element i.
module vec_alu_seq
    import vec_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  instr_t            dec,
    output logic              instr_ready,
    output logic              busy,
    output logic [IDX_W-1:0]  rda_idx,
    input  logic [DATA_W-1:0] rda_data,
    output logic [IDX_W-1:0]  rdb_idx,
    input  logic [DATA_W-1:0] rdb_data,
    output op_e               lane_op,
    output logic [DATA_W-1:0] lane_a,
    output logic [DATA_W-1:0] lane_b,
    input  logic [DATA_W-1:0] lane_res,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data
);
    logic              run_q;
    op_e               op_q;
    mode_e             mode_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  elem_q;
    logic [IDX_W-1:0]  ia_q;
    logic [IDX_W-1:0]  ib_q;
    logic [IDX_W-1:0]  id_q;
    logic [DATA_W-1:0] imm_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] sum_next;
    logic              last;
    logic              step_a;
    logic              step_b;

    assign last   = (elem_q == cnt_q);
    assign step_a = (mode_q != MD_ABS);
    assign step_b = (mode_q == MD_VEC) || (mode_q == MD_ABS);

    // Operand forming: index 0 reads zero, immediate replaces B
    always_comb begin
        lane_a = (ia_q == '0) ? '0 : rda_data;
        if (mode_q == MD_IMM)
            lane_b = imm_q;
        else
            lane_b = (ib_q == '0) ? '0 : rdb_data;
    end

    // Reduction running total including the current A element
    assign sum_next = ((elem_q == '0) ? lane_b : acc_q) + lane_a;

    assign lane_op     = op_q;
    assign rda_idx     = ia_q;
    assign rdb_idx     = ib_q;
    assign busy        = run_q;
    assign instr_ready = !run_q;
    assign wr_idx      = id_q;
    assign wr_data     = (mode_q == MD_SUM) ? sum_next : lane_res;
    assign wr_en       = run_q && (id_q != '0) && ((mode_q != MD_SUM) || last);

    // Instruction capture and per-element index stepping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            op_q   <= OP_AND;
            mode_q <= MD_VEC;
            cnt_q  <= '0;
            elem_q <= '0;
            ia_q   <= '0;
            ib_q   <= '0;
            id_q   <= '0;
            imm_q  <= '0;
            acc_q  <= '0;
        end else if (!run_q) begin
            if (instr_valid && dec.valid) begin
                run_q  <= 1'b1;
                op_q   <= dec.op;
                mode_q <= dec.mode;
                cnt_q  <= dec.cnt;
                elem_q <= '0;
                ia_q   <= dec.a;
                ib_q   <= dec.b;
                id_q   <= dec.d;
                imm_q  <= dec.imm;
                acc_q  <= '0;
            end
        end else begin
            if (last) run_q <= 1'b0;
            elem_q <= elem_q + 1'b1;
            acc_q  <= sum_next;
            if (step_a) ia_q <= ia_q + 1'b1;
            if (step_b) ib_q <= ib_q + 1'b1;
            if (mode_q != MD_SUM) id_q <= id_q + 1'b1;
        end
    end
endmodule

// File: rtl/vec_alu.sv
// Top: vector logic and arithmetic unit over an external register file.
// Assumes one instruction in flight; the next is taken once the last
// element has been written.
module vec_alu
    import vec_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [31:0]       instr_word,
    output logic              instr_ready,
    output logic              busy,
    output logic [6:0]        rda_idx,
    input  logic [31:0]       rda_data,
    output logic [6:0]        rdb_idx,
    input  logic [31:0]       rdb_data,
    output logic              wr_en,
    output logic [6:0]        wr_idx,
    output logic [31:0]       wr_data
);
    instr_t            dec;
    op_e               lane_op;
    logic [DATA_W-1:0] lane_a;
    logic [DATA_W-1:0] lane_b;
    logic [DATA_W-1:0] lane_res;

    vec_alu_decode u_decode (
        .word (instr_word),
        .dec  (dec)
    );

    vec_alu_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .dec         (dec),
        .instr_ready (instr_ready),
        .busy        (busy),
        .rda_idx     (rda_idx),
        .rda_data    (rda_data),
        .rdb_idx     (rdb_idx),
        .rdb_data    (rdb_data),
        .lane_op     (lane_op),
        .lane_a      (lane_a),
        .lane_b      (lane_b),
        .lane_res    (lane_res),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_data     (wr_data)
    );

    vec_alu_lane u_lane (
        .op  (lane_op),
        .opa (lane_a),
        .opb (lane_b),
        .res (lane_res)
    );
endmodule

// File: rtl/vec_alu_chk.sv
// Checker: port-level temporal properties of vec_alu, attached by bind.
// Assumes synchronous active-low reset on rst_n.
module vec_alu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        instr_valid,
    input logic [31:0] instr_word,
    input logic        instr_ready,
    input logic        busy,
    input logic        wr_en,
    input logic [6:0]  wr_idx
);
    logic known_grp;
    assign known_grp = (instr_word[31:28] == 4'hA) || (instr_word[31:28] == 4'hB);

    // R1: a taken word of a known group starts a busy period
    a_r1_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_ready && known_grp) |=> busy);

    // R3: a taken word of an unknown group leaves the block idle
    a_r3_unknown_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_ready && !known_grp) |=> (!busy && !wr_en));

    // R2: no write outside a busy period
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !wr_en);

    // R2: writes on back-to-back cycles go to consecutive destinations
    a_r2_dest_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_idx == 7'($past(wr_idx) + 7'd1)));

    // R10: index 0 is never written
    a_r10_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx != 7'd0));

    // R1: the cycle after reset leaves the block idle
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!busy && instr_ready && !wr_en));
endmodule

bind vec_alu vec_alu_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_word  (instr_word),
    .instr_ready (instr_ready),
    .busy        (busy),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx)
);

// File: tb/vec_alu_bench.sv
// Bench: random plus directed instruction words against a bench model of
// the register file; checks busy length, register contents and reset state.
module vec_alu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic        instr_ready, busy, wr_en;
    logic [6:0]  rda_idx, rdb_idx, wr_idx;
    logic [31:0] rda_data, rdb_data, wr_data;

    logic [31:0] mem  [128];
    logic [31:0] seed [128];
    logic [31:0] expv [128];
    logic        fill_en = 1'b0;
    int          total = 0;
    int          bad = 0;
    int          cycles = 0;
    logic        finished = 1'b0;

    always #5 clk = ~clk;

    vec_alu u_vec_alu (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .instr_ready(instr_ready), .busy(busy), .rda_idx(rda_idx), .rda_data(rda_data),
        .rdb_idx(rdb_idx), .rdb_data(rdb_data), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data)
    );

    assign rda_data = mem[rda_idx];
    assign rdb_data = mem[rdb_idx];

    // Register file model: bulk preload or design write
    always @(posedge clk) begin
        if (fill_en) begin
            for (int i = 0; i < 128; i++) mem[i] <= seed[i];
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !finished) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog R1 actual=%0d expected<150000 cycles", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mrd(input logic [6:0] x);
        return (x == 7'd0) ? 32'd0 : expv[x];
    endfunction

    function automatic logic [31:0] enc(input logic [3:0] g, input logic [2:0] s,
        input logic [3:0] c, input logic [6:0] a, input logic [6:0] d, input logic [6:0] b);
        return {g, c, s, a, d, b};
    endfunction

    // Bench model of one instruction, element by element in order
    task automatic model(input logic [31:0] w);
        logic [3:0]  g = w[31:28];
        logic [2:0]  s = w[23:21];
        int          n = int'(w[27:24]) + 1;
        logic [6:0]  a = w[20:14];
        logic [6:0]  d = w[13:7];
        logic [6:0]  b = w[6:0];
        logic [31:0] imm = {{25{b[6]}}, b};
        logic        ar = (g == 4'hA);
        logic        isv, isi;
        logic [31:0] va, vb, r, acc;
        logic [6:0]  ai, bi, di;
        if (g != 4'hA && g != 4'hB) return;
        if (ar && s == 3'd3) begin
            acc = mrd(b);
            for (int i = 0; i < n; i++) acc = acc + mrd(7'(a + i));
            if (d != 0) expv[d] = acc;
            return;
        end
        isv = ar ? (s == 3'd0 || s == 3'd4 || s == 3'd7) : (s == 3'd0 || s == 3'd3 || s == 3'd6);
        isi = ar ? (s == 3'd2 || s == 3'd6) : (s == 3'd2 || s == 3'd5);
        for (int i = 0; i < n; i++) begin
            ai = (ar && s == 3'd7) ? a : 7'(a + i);
            bi = isv ? 7'(b + i) : b;
            di = 7'(d + i);
            va = mrd(ai);
            vb = isi ? imm : mrd(bi);
            if (ar) begin
                case (s)
                    3'd0, 3'd1, 3'd2: r = va + vb;
                    3'd4, 3'd5, 3'd6: r = va - vb;
                    default:          r = vb[31] ? va - vb : va + vb;
                endcase
            end else begin
                case (s)
                    3'd0, 3'd1, 3'd2: r = va & vb;
                    3'd3, 3'd4, 3'd5: r = va ^ vb;
                    default:          r = va | vb;
                endcase
            end
            if (di != 0) expv[di] = r;
        end
    endtask

    // Issue one word, count busy cycles, compare busy length and registers
    task automatic run(input logic [31:0] w, input string tag);
        int nb = 0;
        int expb = (w[31:28] == 4'hA || w[31:28] == 4'hB) ? int'(w[27:24]) + 1 : 0;
        int badi = -1;
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = w;
        @(negedge clk);
        instr_valid = 1'b0;
        while (busy) begin
            nb++;
            @(negedge clk);
        end
        check(nb == expb, {tag, " R1 R2 busy cycles"}, nb, expb);
        model(w);
        for (int i = 127; i >= 0; i--) if (mem[i] !== expv[i]) badi = i;
        if (badi >= 0)
            check(1'b0, $sformatf("%s regfile r%0d", tag, badi), mem[badi], expv[badi]);
        else
            check(1'b1, tag, 0, 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 128; i++) seed[i] = $urandom;
        seed[0]  = 32'hDEAD_BEEF;
        seed[5]  = 32'h1234_5678;
        seed[20] = 32'hFFFF_FFF0;
        seed[21] = 32'd5;
        for (int i = 0; i < 128; i++) expv[i] = seed[i];
        fill_en = 1'b1;
        repeat (3) @(negedge clk);
        fill_en = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!busy && instr_ready && !wr_en, "R1 reset state",
              {29'd0, busy, instr_ready, wr_en}, 32'h2);

        // R9: A=0 reads zero despite nonzero data at index 0
        run(enc(4'hA, 3'd0, 4'd0, 7'd0, 7'd40, 7'd5), "R9 zero read");
        check(mem[40] == 32'h1234_5678, "R9 value", mem[40], 32'h1234_5678);
        // R8: absolute value, negative then positive B
        run(enc(4'hA, 3'd7, 4'd1, 7'd0, 7'd30, 7'd20), "R8 abs");
        check(mem[30] == 32'd16 && mem[31] == 32'd5, "R8 value", mem[30], 32'd16);
        // R7: reduction with scalar B
        run(enc(4'hA, 3'd3, 4'd2, 7'd50, 7'd60, 7'd20), "R7 sum");
        // R6 R4: XOR with immediate -1
        run(enc(4'hB, 3'd5, 4'd0, 7'd21, 7'd61, 7'h7F), "R6 R4 xor imm");
        check(mem[61] == 32'hFFFF_FFFA, "R6 value", mem[61], 32'hFFFF_FFFA);
        // R10 R11: wrapping run that crosses index 0
        run(enc(4'hB, 3'd0, 4'd2, 7'd125, 7'd127, 7'd126), "R10 R11 wrap");
        check(mem[0] == 32'hDEAD_BEEF, "R10 index0 kept", mem[0], 32'hDEAD_BEEF);
        // R3: unknown group dropped
        run(enc(4'h5, 3'd1, 4'd7, 7'd3, 7'd9, 7'd4), "R3 unknown group");
        // R4 R6: OR with scalar
        run(enc(4'hB, 3'd7, 4'd5, 7'd70, 7'd80, 7'd21), "R4 R6 or scalar");
        // R5: subtract immediate wraps below zero
        run(enc(4'hA, 3'd6, 4'd3, 7'd0, 7'd90, 7'd3), "R5 sub imm wrap");
        // R2: full 16-element vector add
        run(enc(4'hA, 3'd0, 4'd15, 7'd10, 7'd100, 7'd40), "R2 max count");

        // Random mix
        for (int k = 0; k < 150; k++) begin
            int sel = int'($urandom % 10);
            logic [3:0] g = (sel < 4) ? 4'hA : (sel < 8) ? 4'hB : 4'($urandom % 10);
            run(enc(g, 3'($urandom), 4'($urandom), 7'($urandom), 7'($urandom), 7'($urandom)),
                $sformatf("R4 R5 R6 random %0d", k));
        end
        check(mem[0] == 32'hDEAD_BEEF, "R10 index0 final", mem[0], 32'hDEAD_BEEF);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule